// File: doc/BRIEF.md
# Jitter Attenuator Reference Selector

This block decides which timing reference steers the digitally controlled oscillator of an E1 line interface. It weighs a master/slave mode bit, a loss-of-signal flag, a bit that blocks automatic switching, a bit giving the expected rate of the external SYNC clock and a bit that forbids centring. From these it picks one of four references: a free-running centred oscillator, SYNC at 2.048 MHz, SYNC at 8 kHz, or the recovered line clock.

The block also decides whether the external SYNC input is toggling at all. SYNC is brought into the system clock domain through two flops. It counts as present when a rising edge is seen, and as absent once a full timeout window passes with no edge. The window is set by a parameter to more than one 8 kHz period. The select is registered. Every change of reference raises a one-cycle pulse, so the loop filter can clear its phase accumulator. After reset the select holds the free-run reference until the presence detector has produced its first result.

Top module: `ja_ref_sel`

## Requirements
- R1: In slave mode (`master_mode`=0) with `los`=0, `ref_sel` is 4'b1000, which selects the line clock.
- R2: In slave mode with `los`=1 and `hold_line`=0, the selection follows the master-mode rules (R4, R5, R6).
- R3: With `master_mode`=0 and `hold_line`=1, `ref_sel` stays 4'b1000 whatever the value of `los`.
- R4: In master mode with SYNC absent and `force_centre`=0, `ref_sel` is 4'b0001, which selects the free-running centred oscillator.
- R5: In master mode with SYNC present, `ref_sel` is 4'b0010 (2.048 MHz) when `sync_slow`=0 and 4'b0100 (8 kHz) when `sync_slow`=1.
- R6: With `force_centre`=1, the free-run case and the 8 kHz case give `ref_sel`=4'b0000 (no reference). The 2.048 MHz case is not affected.
- R7: In master mode, `los` has no effect on `ref_sel`.
- R8: `sync_present` rises after a rising edge on `sync_in`. It falls after `TIMEOUT_CYC` system clock cycles without an edge.
- R9: `switch_pulse` is high for exactly one cycle, in the cycle where `ref_sel` takes a new value, and is low at all other times.
- R10: After reset, `ref_sel` is 4'b0001 until the first SYNC edge or the first expiry of the timeout window. `ref_sel` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1 = master, 0 = slave |
| los | input | 1 | Loss of signal on the line |
| hold_line | input | 1 | Blocks automatic fallback from the line clock |
| sync_slow | input | 1 | Expected SYNC rate: 0 = 2.048 MHz, 1 = 8 kHz |
| force_centre | input | 1 | Forbids centring; should stay 0 |
| sync_in | input | 1 | External SYNC clock, asynchronous |
| ref_sel | output | 4 | One-hot reference: [0] free-run, [1] SYNC 2.048 MHz, [2] SYNC 8 kHz, [3] line |
| sync_present | output | 1 | SYNC judged to be toggling |
| switch_pulse | output | 1 | One-cycle pulse on each change of `ref_sel` |

## Verification
Random combinations of the five control bits are driven with SYNC in three states: silent, toggling fast, and toggling slower but still inside the window. Each combination is checked against a model of the rules. The random mix shows that `los` matters only in slave mode and that `hold_line` overrides it. It also shows that the selected reference follows real SYNC activity, not the rate bit alone. Directed cases cover the period just after reset before the first result, the timing of the SYNC timeout, and a single reference change that must produce exactly one pulse.

// File: rtl/ja_ref_sel.sv
module ja_ref_sel #(
  parameter int TIMEOUT_CYC = 3072
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       master_mode,
  input  logic       los,
  input  logic       hold_line,
  input  logic       sync_slow,
  input  logic       force_centre,
  input  logic       sync_in,
  output logic [3:0] ref_sel,
  output logic       sync_present,
  output logic       switch_pulse
);
  localparam int CW = $clog2(TIMEOUT_CYC);
  localparam logic [3:0] SEL_FREE = 4'b0001;
  localparam logic [3:0] SEL_S2M  = 4'b0010;
  localparam logic [3:0] SEL_S8K  = 4'b0100;
  localparam logic [3:0] SEL_LINE = 4'b1000;

  logic [2:0]    sync_sh;
  logic [CW-1:0] win_cnt;
  logic          primed_q;
  logic [3:0]    nxt_sel;

  wire sync_edge = sync_sh[1] & ~sync_sh[2];
  wire win_end   = (win_cnt == CW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_sh      <= '0;
      win_cnt      <= '0;
      sync_present <= 1'b0;
      primed_q     <= 1'b0;
    end else begin
      sync_sh <= {sync_sh[1:0], sync_in};
      if (sync_edge) begin
        win_cnt      <= '0;
        sync_present <= 1'b1;
        primed_q     <= 1'b1;
      end else if (win_end) begin
        win_cnt      <= '0;
        sync_present <= 1'b0;
        primed_q     <= 1'b1;
      end else begin
        win_cnt <= win_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (!primed_q)
      nxt_sel = SEL_FREE;
    else if (!master_mode && (!los || hold_line))
      nxt_sel = SEL_LINE;
    else if (sync_present)
      nxt_sel = sync_slow ? (force_centre ? 4'b0000 : SEL_S8K) : SEL_S2M;
    else
      nxt_sel = force_centre ? 4'b0000 : SEL_FREE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_sel      <= SEL_FREE;
      switch_pulse <= 1'b0;
    end else begin
      ref_sel      <= nxt_sel;
      switch_pulse <= (nxt_sel != ref_sel);
    end
  end
endmodule

// File: rtl/ja_ref_sel_chk.sv
module ja_ref_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       master_mode,
  input logic       hold_line,
  input logic       force_centre,
  input logic       primed,
  input logic       sync_present,
  input logic [3:0] ref_sel,
  input logic       switch_pulse
);
  assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ref_sel));

  assert_change_pulses_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_sel != $past(ref_sel)) |-> switch_pulse);

  assert_pulse_needs_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |-> (ref_sel != $past(ref_sel)));

  assert_hold_keeps_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !master_mode && hold_line) |=> (ref_sel == 4'b1000));

  assert_freerun_no_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && master_mode && !sync_present && !force_centre) |=> (ref_sel == 4'b0001));
endmodule

bind ja_ref_sel ja_ref_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .hold_line(hold_line),
  .force_centre(force_centre), .primed(primed_q), .sync_present(sync_present),
  .ref_sel(ref_sel), .switch_pulse(switch_pulse)
);

// File: tb/sim_ja_ref_sel.sv
module sim_ja_ref_sel;
  localparam int CLK_PER = 10;
  localparam int TMO = 64;

  logic clk = 0, rst_n = 0;
  logic master_mode = 0, los = 0, hold_line = 0, sync_slow = 0, force_centre = 0, sync_in = 0;
  logic [3:0] ref_sel;
  logic sync_present, switch_pulse;
  int errors = 0, checks = 0, half = 0, tcnt = 0;

  ja_ref_sel #(.TIMEOUT_CYC(TMO)) u0 (.*);

  always #(CLK_PER/2) clk = ~clk;

  initial begin
    #(CLK_PER * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial forever begin
    @(posedge clk);
    if (half == 0) begin sync_in <= 1'b0; tcnt = 0; end
    else if (++tcnt >= half) begin tcnt = 0; sync_in <= ~sync_in; end
  end

  function automatic logic [3:0] exp_sel(logic m, logic l, logic h, logic s, logic f, logic p);
    if (!m && (!l || h)) return 4'b1000;
    if (p) return s ? (f ? 4'b0000 : 4'b0100) : 4'b0010;
    return f ? 4'b0000 : 4'b0001;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int pulses;
    void'($urandom(32'h5eed1));
    wait_cyc(3);
    chk("R10 reset sel", ref_sel, 4'b0001);
    chk("R8 reset present", sync_present, 0);
    chk("R9 reset pulse", switch_pulse, 0);
    rst_n = 1;
    wait_cyc(20);
    chk("R10 before first window", ref_sel, 4'b0001);
    wait_cyc(80);
    chk("R1 slave line after window", ref_sel, 4'b1000);

    pulses = 0;
    los = 1;
    for (int i = 0; i < 10; i++) begin @(negedge clk); pulses += switch_pulse; end
    chk("R9 one pulse on change", pulses, 1);
    chk("R2 los falls back to free-run", ref_sel, 4'b0001);

    master_mode = 1; los = 0; half = 4;
    wait_cyc(150);
    chk("R8 present with fast sync", sync_present, 1);
    chk("R5 sync 2M", ref_sel, 4'b0010);
    half = 0;
    wait_cyc(40);
    chk("R8 still present inside window", sync_present, 1);
    wait_cyc(60);
    chk("R8 absent after window", sync_present, 0);
    chk("R4 free-run no sync", ref_sel, 4'b0001);

    for (int k = 0; k < 120; k++) begin
      int sm;
      master_mode = $urandom_range(0, 1);
      los = $urandom_range(0, 1);
      hold_line = $urandom_range(0, 1);
      sync_slow = $urandom_range(0, 1);
      force_centre = $urandom_range(0, 1);
      sm = $urandom_range(0, 2);
      half = (sm == 0) ? 0 : (sm == 1 ? 4 : 20);
      wait_cyc(200);
      chk(master_mode ? "R7 R5 R6 master select" :
          (hold_line ? "R3 hold select" : "R1 R2 slave select"),
          ref_sel, exp_sel(master_mode, los, hold_line, sync_slow, force_centre, sm != 0));
      chk("R8 presence", sync_present, sm != 0);
      chk("R9 quiet when steady", switch_pulse, 0);
    end

    master_mode = 1; los = 1; hold_line = 0; sync_slow = 1; force_centre = 1; half = 20;
    wait_cyc(200);
    chk("R6 8k with force_centre", ref_sel, 4'b0000);
    sync_slow = 0;
    wait_cyc(5);
    chk("R6 2M unaffected by force_centre", ref_sel, 4'b0010);
    master_mode = 0; hold_line = 1;
    wait_cyc(5);
    chk("R3 hold during los", ref_sel, 4'b1000);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule